// File: doc/BRIEF.md
# Presettable Synchronous Cascadable Binary Counter

This block is a synchronous binary up-counter built from identical counter stages. Every stage has a synchronous active-low clear, an active-low parallel load and two count enables. One enable, `cnt_en_p`, goes to all stages side by side. The other, `cnt_en_t`, carries the terminal count from stage to stage. Because of this split, a chain of narrow stages behaves as one wide counter. All state registers sample on the same rising clock edge. No register is clocked from another register's output.

The top module chains `N_STAGES` stages of `STAGE_W` bits each. Clear wins over load, and load wins over counting. Load ignores both enables. The counter advances only when both enables are high. The terminal-count output is combinational, so a further chain can be attached outside the block. The `LOOKAHEAD` parameter chooses how each stage's carry enable is formed. With 0, the previous stage's terminal count feeds the next stage. With 1, each stage's enable is a direct AND of the incoming enable and the all-ones state of every lower stage.

Top module: `sync_preset_counter`

## Requirements
- R1: While `clr_n` is low at a rising clock edge, `q` becomes all zeros after that edge, whatever `load_n`, `cnt_en_p` and `cnt_en_t` are.
- R2: When `clr_n` and `load_n` are both low at the same edge, the clear wins and `q` becomes zero, not `din`.
- R3: With `clr_n` high and `load_n` low at an edge, `q` takes the value of `din` after that edge, for any levels of `cnt_en_p` and `cnt_en_t`.
- R4: With `clr_n` and `load_n` high and both enables high at an edge, `q` increases by exactly one.
- R5: Counting from the all-ones value gives all zeros on the next edge.
- R6: With `clr_n` and `load_n` high and either enable low at an edge, `q` keeps its value.
- R7: `tc_out` is high exactly when `cnt_en_t` is high and every bit of `q` is 1. It follows `cnt_en_t` without waiting for a clock edge.
- R8: A carry passes across stage boundaries. Stage k+1 advances on an edge exactly when stage k's terminal count is high and counting is enabled, so the chain counts as one binary number of `N_STAGES*STAGE_W` bits (bit 0 of `q` is the least significant).
- R9: `q` changes only at rising clock edges. A change on `clr_n`, `load_n` or the enables between edges leaves `q` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages update on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | N_STAGES*STAGE_W | Parallel load value |
| cnt_en_p | input | 1 | Count enable fed to all stages side by side |
| cnt_en_t | input | 1 | Count enable that also gates the terminal count |
| q | output | N_STAGES*STAGE_W | Counter state |
| tc_out | output | 1 | Terminal count for further cascading |

## Verification
The bench builds the counter as three stages of two bits each with the chained carry. With these values the whole count space is only 64 states, so the bench can step through a full wrap from all-ones to zero in a few dozen cycles. At the same time there are two internal stage boundaries, so a carry that crosses both of them (0x0F to 0x10) and a full ripple at wrap are both reached. Priority, hold and terminal-count cases run on the same instance, and every outcome is compared against a scoreboard model of the whole counter width.

// File: rtl/spc_pkg.sv
package spc_pkg;

   typedef enum logic [1:0] {
      MODE_HOLD  = 2'd0,
      MODE_COUNT = 2'd1,
      MODE_LOAD  = 2'd2,
      MODE_CLEAR = 2'd3
   } spc_mode_e;

   function automatic spc_mode_e pick_mode(input logic clr_n, input logic load_n,
                                           input logic en_p, input logic en_t);
      if (!clr_n)            return MODE_CLEAR;
      else if (!load_n)      return MODE_LOAD;
      else if (en_p && en_t) return MODE_COUNT;
      else                   return MODE_HOLD;
   endfunction

endpackage

// File: rtl/spc_mode_dec.sv
module spc_mode_dec
   import spc_pkg::*;
(
   input  logic      clr_n,
   input  logic      load_n,
   input  logic      en_p,
   input  logic      en_t,
   output spc_mode_e mode
);

   always_comb begin
      mode = pick_mode(clr_n, load_n, en_p, en_t);
   end

endmodule

// File: rtl/spc_stage.sv
module spc_stage
   import spc_pkg::*;
#(
   parameter int STAGE_W = 4
) (
   input  logic               clk,
   input  logic               clr_n,
   input  logic               load_n,
   input  logic               en_p,
   input  logic               en_t,
   input  logic [STAGE_W-1:0] d,
   output logic [STAGE_W-1:0] q,
   output logic               tc
);

   localparam logic [STAGE_W-1:0] ALL_ONES = '1;

   generate
      if (STAGE_W < 1) begin : g_bad_width
         $error("spc_stage: STAGE_W must be at least 1");
      end
   endgenerate

   spc_mode_e mode;
   logic [STAGE_W-1:0] q_r;
   logic [STAGE_W-1:0] q_next;

   spc_mode_dec u_dec (
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (en_p),
      .en_t   (en_t),
      .mode   (mode)
   );

   always_comb begin
      unique case (mode)
         MODE_CLEAR: q_next = '0;
         MODE_LOAD:  q_next = d;
         MODE_COUNT: q_next = q_r + STAGE_W'(1);
         default:    q_next = q_r;
      endcase
   end

   always_ff @(posedge clk) begin
      q_r <= q_next;
   end

   assign q  = q_r;
   assign tc = en_t && (q_r == ALL_ONES);

   // Assertion support: properties are armed once a clear has been seen.
   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (!clr_n) armed <= 1'b1;
   end

   a_r1_clear_zero: assert property (@(posedge clk)
      !clr_n |=> (q == '0));

   a_r2_clear_over_load: assert property (@(posedge clk)
      (!clr_n && !load_n) |=> (q == '0));

   a_r3_load_value: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !load_n) |=> (q == $past(d)));

   a_r4_count_step: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && en_p && en_t) |=> (q == STAGE_W'($past(q) + STAGE_W'(1))));

   a_r6_hold: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));

endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
   import spc_pkg::*;
#(
   parameter int STAGE_W   = 4,
   parameter int N_STAGES  = 3,
   parameter bit LOOKAHEAD = 1'b0
) (
   input  logic                          clk,
   input  logic                          clr_n,
   input  logic                          load_n,
   input  logic [N_STAGES*STAGE_W-1:0]   din,
   input  logic                          cnt_en_p,
   input  logic                          cnt_en_t,
   output logic [N_STAGES*STAGE_W-1:0]   q,
   output logic                          tc_out
);

   localparam int TOTAL_W = N_STAGES * STAGE_W;
   localparam logic [TOTAL_W-1:0] TOTAL_ONES = '1;

   generate
      if (N_STAGES < 2) begin : g_bad_stages
         $error("sync_preset_counter: N_STAGES must be at least 2");
      end
      if (STAGE_W < 1) begin : g_bad_width
         $error("sync_preset_counter: STAGE_W must be at least 1");
      end
   endgenerate

   logic [N_STAGES-1:0] cet_vec;
   logic [N_STAGES-1:0] tc_vec;
   logic [TOTAL_W-1:0]  q_int;

   assign cet_vec[0] = cnt_en_t;

   generate
      if (LOOKAHEAD) begin : g_look
         logic [N_STAGES-2:0] full_vec;
         for (genvar j = 0; j < N_STAGES-1; j++) begin : g_full
            assign full_vec[j] = &q_int[j*STAGE_W +: STAGE_W];
         end
         for (genvar k = 1; k < N_STAGES; k++) begin : g_en
            assign cet_vec[k] = cnt_en_t && (&full_vec[k-1:0]);
         end
      end else begin : g_chain
         for (genvar k = 1; k < N_STAGES; k++) begin : g_en
            assign cet_vec[k] = tc_vec[k-1];
         end
      end
   endgenerate

   generate
      for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
         spc_stage #(.STAGE_W(STAGE_W)) u_stage (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_p   (cnt_en_p),
            .en_t   (cet_vec[s]),
            .d      (din[s*STAGE_W +: STAGE_W]),
            .q      (q_int[s*STAGE_W +: STAGE_W]),
            .tc     (tc_vec[s])
         );
      end
   endgenerate

   assign q      = q_int;
   assign tc_out = tc_vec[N_STAGES-1];

   logic armed = 1'b0;
   always_ff @(posedge clk) begin
      if (!clr_n) armed <= 1'b1;
   end

   // R8: the whole chain steps as one wide binary number
   a_r8_wide_step: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && cnt_en_p && cnt_en_t) |=> (q == TOTAL_W'($past(q) + TOTAL_W'(1))));

   // R5: all-ones wraps to zero across every stage
   a_r5_wrap: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && cnt_en_p && cnt_en_t && q == TOTAL_ONES) |=> (q == '0));

   // R7: terminal count only at all-ones with the carry enable high
   a_r7_tc_full: assert property (@(posedge clk) disable iff (!armed)
      tc_out |-> (cnt_en_t && q == TOTAL_ONES));

   generate
      for (genvar k = 0; k < N_STAGES-1; k++) begin : g_carry_chk
         // R8: a stage's terminal count advances the next stage
         a_r8_stage_carry: assert property (@(posedge clk) disable iff (!armed)
            (clr_n && load_n && cnt_en_p && tc_vec[k])
            |=> (q[(k+1)*STAGE_W +: STAGE_W] ==
                 STAGE_W'($past(q[(k+1)*STAGE_W +: STAGE_W]) + STAGE_W'(1))));
      end
   endgenerate

endmodule

// File: tb/sync_preset_counter_tb_top.sv
`timescale 1ns/1ps
module sync_preset_counter_tb_top;

   localparam int SW = 2;
   localparam int NS = 3;
   localparam int W  = SW * NS;
   localparam logic [W-1:0] ONES = '1;

   logic         clk = 1'b0;
   logic         clr_n = 1'b0;
   logic         load_n = 1'b1;
   logic         cnt_en_p = 1'b0;
   logic         cnt_en_t = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] q;
   logic         tc_out;

   always #2.5 clk = ~clk;

   sync_preset_counter #(.STAGE_W(SW), .N_STAGES(NS), .LOOKAHEAD(1'b0)) dut_i (
      .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
      .cnt_en_p(cnt_en_p), .cnt_en_t(cnt_en_t), .q(q), .tc_out(tc_out)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [W-1:0] exp_q[$];
   string        tag_q[$];
   logic [W-1:0] mdl;
   bit           mdl_ok = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // Driver: applies one cycle of stimulus and pushes the expected state.
   task automatic step(input logic c, input logic l, input logic p, input logic t,
                       input logic [W-1:0] d, input string tag);
      logic [W-1:0] nxt;
      @(negedge clk);
      clr_n = c; load_n = l; cnt_en_p = p; cnt_en_t = t; din = d;
      #0.5;
      if (mdl_ok) begin
         check(q === mdl, "R9", "q between edges", q, mdl);
         check(tc_out === (t && mdl == ONES), "R7", "tc_out",
               {{(W-1){1'b0}}, tc_out}, {{(W-1){1'b0}}, (t && mdl == ONES)});
      end
      if (!c)          nxt = '0;
      else if (!l)     nxt = d;
      else if (p && t) nxt = mdl + W'(1);
      else             nxt = mdl;
      mdl = nxt;
      mdl_ok = 1'b1;
      exp_q.push_back(nxt);
      tag_q.push_back(tag);
   endtask

   // Monitor: compares each result just after the edge that produced it.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [W-1:0] e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(q === e, tg, "q after edge", q, e);
         end
      end
   end

   initial begin
      // R1: clear wins over an active count
      step(1'b0, 1'b1, 1'b1, 1'b1, 6'h00, "R1");
      step(1'b0, 1'b1, 1'b1, 1'b1, 6'h00, "R1");
      // R3: load with both enables low, then load over an active count
      step(1'b1, 1'b0, 1'b0, 1'b0, 6'h2A, "R3");
      // R2: clear and load together -> zero
      step(1'b0, 1'b0, 1'b1, 1'b1, 6'h15, "R2");
      step(1'b1, 1'b0, 1'b1, 1'b1, 6'h05, "R3");
      step(1'b1, 1'b0, 1'b1, 1'b0, 6'h33, "R3");
      // R6: hold with either enable low
      step(1'b1, 1'b1, 1'b0, 1'b1, 6'h00, "R6");
      step(1'b1, 1'b1, 1'b0, 1'b1, 6'h00, "R6");
      step(1'b1, 1'b1, 1'b1, 1'b0, 6'h00, "R6");
      step(1'b1, 1'b1, 1'b0, 1'b0, 6'h00, "R6");
      // R8: carry across two stage boundaries 0x0F -> 0x10
      step(1'b1, 1'b0, 1'b0, 1'b0, 6'h0F, "R3");
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 6'h00, "R8");
      // R8: carry out of stage 0 only, 0x03 -> 0x04
      step(1'b1, 1'b0, 1'b0, 1'b0, 6'h03, "R3");
      step(1'b1, 1'b1, 1'b1, 1'b1, 6'h00, "R8");
      // R7: terminal count masked by low carry enable at all-ones
      step(1'b1, 1'b0, 1'b0, 1'b0, 6'h3F, "R3");
      step(1'b1, 1'b1, 1'b1, 1'b0, 6'h00, "R6");
      step(1'b1, 1'b1, 1'b0, 1'b1, 6'h00, "R7");
      // R5: wrap from all-ones to zero
      step(1'b1, 1'b0, 1'b0, 1'b0, 6'h3D, "R3");
      for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 6'h00, "R5");
      // R4: long count run through a full wrap
      for (int i = 0; i < 70; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 6'h00, "R4");
      // R1: clear from a non-zero value with load and count active
      step(1'b0, 1'b0, 1'b1, 1'b1, 6'h2C, "R1");
      step(1'b1, 1'b1, 1'b0, 1'b0, 6'h00, "R6");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule